// File: doc/BRIEF.md
# Receive byte-to-word queue controller

This block sits between a byte-wide receive FIFO and a word-wide receive queue. Each FIFO entry is one frame byte together with four status bits: end of frame, FIFO overflow, PHY receive error and odd-nibble ending. The block packs the bytes into 32-bit words and checks the frame CRC-32 while the frame passes through. Two plain control inputs choose whether the trailing four CRC bytes are kept in the stored data. They also choose whether padding after a short payload is kept. The payload length is taken from the length/type field.

Status bits are ORed over the whole frame and held until the entry with end of frame arrives. One status word per frame is then written to a status FIFO, and the held bits are cleared. The block looks at the status FIFO's full flag when a frame's first byte is read. If the flag is set, every byte of that frame is consumed and thrown away. No word and no status word are produced for it, so stored frames and status words always pair one to one.

Both data paths use valid/ready. A byte is taken when `in_valid` and `in_ready` are both high at a clock edge. The block never raises `in_ready` in the clock after a byte was taken. It also lowers `in_ready` while its output word register is full and the queue is not ready, unless the frame is being dropped. A word is transferred when `q_valid` and `q_ready` are both high. While `q_ready` is low, `q_valid`, `q_data`, `q_be` and `q_last` hold their values.

Top module: `rxq_word_packer`

## Requirements
- R1: Kept bytes are packed little-endian. The first kept byte of a word sits in `q_data[7:0]` and the next in `q_data[15:8]`. Every word that is not the last of its frame carries `q_be` all ones.
- R2: The last word of a frame has `q_last` set. Its `q_be` has the low lanes set and nothing else, and the number of set lanes equals the kept byte count minus four times the number of earlier words. A frame with no kept bytes produces no word.
- R3: `in_ready` is low in the clock cycle that follows any accepted byte, so no byte is taken on two consecutive clocks.
- R4: For each frame that is not dropped, exactly one status word is written, with `st_we` high for one cycle after its end-of-frame entry. Bits [4 +: CNT_W] hold the number of entries in the frame. Bits [4+CNT_W +: CNT_W] hold the number of bytes written to the queue.
- R5: Status bits 1, 2 and 3 are the OR, over every entry of the frame, of overflow, receive error and odd-nibble respectively. They start from zero for every frame.
- R6: Status bit 0 is set when the CRC-32 does not check out. The CRC uses the reflected polynomial 0xEDB88320 with initial value all ones and runs over every entry of the frame, CRC bytes included. The frame is good when the bit-reversed register equals 0xC704DD7B.
- R7: When `cfg_strip_crc` is high, the last four entries of a frame are not written to the queue. When it is low, they are written.
- R8: Let L be the big-endian value of entries 12 (high byte) and 13 (low byte), counting entries from 0. When `cfg_strip_pad` is high and L < 46, a non-tail entry with index at or above 14 + L is not written. In all other cases, non-tail entries are written.
- R9: When `st_full` is high as a frame's first entry is accepted, the whole frame is consumed with no queue word and no status write.
- R10: While `q_valid` is high and `q_ready` is low, the queue outputs hold steady, and no kept byte is lost or duplicated under back-pressure.
- R11: After reset, `in_ready` is high, and `q_valid` and `st_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_strip_pad | input | 1 | Remove padding after a short payload |
| cfg_strip_crc | input | 1 | Remove the four CRC bytes |
| in_valid | input | 1 | Byte FIFO entry available |
| in_ready | output | 1 | Entry taken at this edge when valid |
| in_data | input | 8 | Frame byte |
| in_eof | input | 1 | Entry ends the frame |
| in_ovf | input | 1 | FIFO overflow flag of the entry |
| in_rxer | input | 1 | PHY receive-error flag of the entry |
| in_odd | input | 1 | Frame ended on an odd nibble |
| q_valid | output | 1 | Word available to the receive queue |
| q_ready | input | 1 | Receive queue accepts the word |
| q_data | output | 8*BYTES | Packed word, little-endian |
| q_be | output | BYTES | Valid byte lanes of the word |
| q_last | output | 1 | Final word of a frame |
| st_full | input | 1 | Status FIFO has no free slot |
| st_we | output | 1 | Write strobe into the status FIFO |
| st_word | output | 4+2*CNT_W | Frame status word |

## Verification
The bench builds the block with CNT_W = 8 and BYTES = 4. Eight-bit counts hold every frame length in the sweep, and four lanes keep the word remainder cycling through all of its values. The bench sweeps frame lengths from 4 to 72 against all four strip settings. The length field of each frame is derived from the frame length, so it lands both below and above the 46-byte threshold and the pad cut falls at many different offsets. Frames of exactly four entries leave nothing to store once the CRC is stripped. Back-pressure alternates between frames, and the bench also injects corrupted CRCs, per-entry status flags and a full status FIFO.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int TAIL_N  = 4;   // CRC field length in bytes
  localparam int HDR_N   = 14;  // bytes ahead of the payload
  localparam int MIN_PAY = 46;  // shortest unpadded payload

  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
  localparam logic [31:0] CRC_GOOD = 32'hC704DD7B;

  typedef enum logic [1:0] {PH_RUN, PH_FLUSH, PH_FIN} phase_e;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int k = 0; k < 8; k++) begin
      r = (r[0] ^ b[k]) ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction

  function automatic logic [31:0] rev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction
endpackage

// File: rtl/rxq_crc_check.sv
module rxq_crc_check
  import rxq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic [7:0] din,
  output logic       good
);
  timeunit 1ns;
  timeprecision 100ps;

  logic [31:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc_q <= '1;
    else if (clr) crc_q <= '1;
    else if (en)  crc_q <= crc_step(crc_q, din);
  end

  assign good = (rev32(crc_q) == CRC_GOOD);
endmodule

// File: rtl/rxq_tail_hold.sv
module rxq_tail_hold #(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       push,
  input  logic       pop,
  input  logic [7:0] din,
  output logic       full,
  output logic       empty,
  output logic [7:0] head
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int FW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]    slot [DEPTH];
  logic [FW-1:0] fill;

  assign full  = (fill == FW'(DEPTH));
  assign empty = (fill == '0);
  assign head  = slot[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill <= '0;
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else if (clr) begin
      fill <= '0;
    end else if (push) begin
      if (full) begin
        for (int i = 0; i < DEPTH - 1; i++) slot[i] <= slot[i+1];
        slot[DEPTH-1] <= din;
      end else begin
        slot[fill[IW-1:0]] <= din;
        fill <= fill + FW'(1);
      end
    end else if (pop && !empty) begin
      for (int i = 0; i < DEPTH - 1; i++) slot[i] <= slot[i+1];
      fill <= fill - FW'(1);
    end
  end
endmodule

// File: rtl/rxq_lane_pack.sv
module rxq_lane_pack #(
  parameter int BYTES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic [7:0]         din,
  input  logic               fin,
  output logic               can_take,
  output logic               q_valid,
  input  logic               q_ready,
  output logic [8*BYTES-1:0] q_data,
  output logic [BYTES-1:0]   q_be,
  output logic               q_last
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int WORD_W = 8 * BYTES;
  localparam int CW     = $clog2(BYTES + 1);

  logic [WORD_W-1:0] acc;
  logic [CW-1:0]     cnt;
  logic [BYTES-1:0]  be_part;
  logic              wrap;
  logic              close;

  assign can_take = !q_valid || q_ready;
  assign wrap     = push && (cnt == CW'(BYTES));
  assign close    = fin && (cnt != '0);

  // one lane register per byte position
  for (genvar j = 0; j < BYTES; j++) begin : g_lane
    assign be_part[j] = (CW'(j) < cnt);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        acc[8*j +: 8] <= '0;
      else if (wrap)
        acc[8*j +: 8] <= (j == 0) ? din : 8'h00;
      else if (fin)
        acc[8*j +: 8] <= 8'h00;
      else if (push && cnt == CW'(j))
        acc[8*j +: 8] <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (wrap)      cnt <= CW'(1);
    else if (push)      cnt <= cnt + CW'(1);
    else if (fin)       cnt <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_data  <= '0;
      q_be    <= '0;
      q_last  <= 1'b0;
    end else begin
      if (q_valid && q_ready) q_valid <= 1'b0;
      if (wrap) begin
        q_valid <= 1'b1;
        q_data  <= acc;
        q_be    <= '1;
        q_last  <= 1'b0;
      end else if (close) begin
        q_valid <= 1'b1;
        q_data  <= acc;
        q_be    <= be_part;
        q_last  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rxq_frame_tally.sv
module rxq_frame_tally #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             take,
  input  logic             ovf,
  input  logic             rxer,
  input  logic             odd,
  input  logic             kept,
  output logic [CNT_W-1:0] frame_len,
  output logic [CNT_W-1:0] kept_len,
  output logic             any_ovf,
  output logic             any_rxer,
  output logic             any_odd
);
  timeunit 1ns;
  timeprecision 100ps;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_len <= '0;
      any_ovf   <= 1'b0;
      any_rxer  <= 1'b0;
      any_odd   <= 1'b0;
    end else if (clr) begin
      frame_len <= '0;
      any_ovf   <= 1'b0;
      any_rxer  <= 1'b0;
      any_odd   <= 1'b0;
    end else if (take) begin
      frame_len <= frame_len + CNT_W'(1);
      any_ovf   <= any_ovf  | ovf;
      any_rxer  <= any_rxer | rxer;
      any_odd   <= any_odd  | odd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     kept_len <= '0;
    else if (clr)   kept_len <= '0;
    else if (kept)  kept_len <= kept_len + CNT_W'(1);
  end
endmodule

// File: rtl/rxq_word_packer.sv
module rxq_word_packer
  import rxq_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int BYTES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_strip_pad,
  input  logic                   cfg_strip_crc,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [7:0]             in_data,
  input  logic                   in_eof,
  input  logic                   in_ovf,
  input  logic                   in_rxer,
  input  logic                   in_odd,
  output logic                   q_valid,
  input  logic                   q_ready,
  output logic [8*BYTES-1:0]     q_data,
  output logic [BYTES-1:0]       q_be,
  output logic                   q_last,
  input  logic                   st_full,
  output logic                   st_we,
  output logic [4+2*CNT_W-1:0]   st_word
);
  timeunit 1ns;
  timeprecision 100ps;

  phase_e     phase;
  logic       rd_prev;
  logic       in_frame;
  logic       drop_q;
  logic [7:0] len_hi, len_lo;

  logic       drop_now, rd, keep_rd, pack_ok;
  logic       win_full, win_empty, win_clr, win_pop;
  logic [7:0] win_head;
  logic       pad_cut, fwd_run, fwd_flush, pack_push, fin_go;
  logic       crc_good;

  logic [CNT_W-1:0] frame_len, kept_len, pop_idx;
  logic             any_ovf, any_rxer, any_odd;
  logic [15:0]      len_field;

  // read side: every other clock at most, drop decision on the first byte
  assign drop_now = in_frame ? drop_q : st_full;
  assign in_ready = (phase == PH_RUN) && !rd_prev && (drop_now || pack_ok);
  assign rd       = in_valid && in_ready;
  assign keep_rd  = rd && !drop_now;

  // padding decision for the byte leaving the tail window
  assign len_field = {len_hi, len_lo};
  assign pop_idx   = frame_len - CNT_W'(TAIL_N);
  assign pad_cut   = cfg_strip_pad && (len_field < 16'(MIN_PAY)) &&
                     (32'(pop_idx) >= 32'(len_field) + 32'(HDR_N));

  assign fwd_run   = keep_rd && win_full && !pad_cut;
  assign win_clr   = (phase == PH_FLUSH) && (cfg_strip_crc || win_empty);
  assign win_pop   = (phase == PH_FLUSH) && !win_clr && pack_ok;
  assign fwd_flush = win_pop;
  assign pack_push = fwd_run || fwd_flush;
  assign fin_go    = (phase == PH_FIN) && pack_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_RUN;
      rd_prev  <= 1'b0;
      in_frame <= 1'b0;
      drop_q   <= 1'b0;
      len_hi   <= '0;
      len_lo   <= '0;
    end else begin
      rd_prev <= rd;
      if (rd && !in_frame) drop_q <= st_full;
      if (rd && !(in_eof && drop_now)) in_frame <= 1'b1;
      if (rd && in_eof && drop_now)    in_frame <= 1'b0;
      if (fin_go)                      in_frame <= 1'b0;
      if (keep_rd && frame_len == CNT_W'(HDR_N - 2)) len_hi <= in_data;
      if (keep_rd && frame_len == CNT_W'(HDR_N - 1)) len_lo <= in_data;
      case (phase)
        PH_RUN:   if (keep_rd && in_eof) phase <= PH_FLUSH;
        PH_FLUSH: if (win_clr)           phase <= PH_FIN;
        PH_FIN:   if (fin_go)            phase <= PH_RUN;
        default:                         phase <= PH_RUN;
      endcase
    end
  end

  rxq_tail_hold #(.DEPTH(TAIL_N)) u_tail (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (win_clr),
    .push  (keep_rd),
    .pop   (win_pop),
    .din   (in_data),
    .full  (win_full),
    .empty (win_empty),
    .head  (win_head)
  );

  rxq_crc_check u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (fin_go),
    .en    (keep_rd),
    .din   (in_data),
    .good  (crc_good)
  );

  rxq_lane_pack #(.BYTES(BYTES)) u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (pack_push),
    .din      (win_head),
    .fin      (fin_go),
    .can_take (pack_ok),
    .q_valid  (q_valid),
    .q_ready  (q_ready),
    .q_data   (q_data),
    .q_be     (q_be),
    .q_last   (q_last)
  );

  rxq_frame_tally #(.CNT_W(CNT_W)) u_tally (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (fin_go),
    .take      (keep_rd),
    .ovf       (in_ovf),
    .rxer      (in_rxer),
    .odd       (in_odd),
    .kept      (pack_push),
    .frame_len (frame_len),
    .kept_len  (kept_len),
    .any_ovf   (any_ovf),
    .any_rxer  (any_rxer),
    .any_odd   (any_odd)
  );

  assign st_we   = fin_go;
  assign st_word = {kept_len, frame_len, any_odd, any_rxer, any_ovf, !crc_good};
endmodule

// File: rtl/rxq_word_packer_chk.sv
module rxq_word_packer_chk #(
  parameter int BYTES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               q_valid,
  input logic               q_ready,
  input logic [8*BYTES-1:0] q_data,
  input logic [BYTES-1:0]   q_be,
  input logic               q_last,
  input logic               st_we,
  input logic               st_full
);
  timeunit 1ns;
  timeprecision 100ps;

  p_read_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  p_q_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && !q_ready) |=> (q_valid && $stable(q_data) && $stable(q_be) && $stable(q_last)));

  p_full_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && !q_last) |-> (&q_be));

  p_be_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |-> ((q_be != '0) && (((q_be + 1'b1) & q_be) == '0)));

  p_st_room_r9: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |-> !st_full);

  p_single_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |=> !st_we);
endmodule

bind rxq_word_packer rxq_word_packer_chk #(.BYTES(BYTES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .q_valid  (q_valid),
  .q_ready  (q_ready),
  .q_data   (q_data),
  .q_be     (q_be),
  .q_last   (q_last),
  .st_we    (st_we),
  .st_full  (st_full)
);

// File: tb/test_rxq_word_packer.sv
module test_rxq_word_packer;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int CW  = 8;
  localparam int BY  = 4;
  localparam int STW = 4 + 2 * CW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_strip_pad = 1'b0, cfg_strip_crc = 1'b0;
  logic in_valid = 1'b0, in_eof = 1'b0, in_ovf = 1'b0, in_rxer = 1'b0, in_odd = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready;
  logic q_valid, q_last;
  logic q_ready = 1'b1;
  logic [8*BY-1:0] q_data;
  logic [BY-1:0] q_be;
  logic st_full = 1'b0;
  logic st_we;
  logic [STW-1:0] st_word;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  bit bp = 0;
  int cyc = 0;

  logic [7:0] got [0:255];
  int got_n = 0, last_n = 0, st_n = 0, bad_be = 0, pace_bad = 0;
  logic [STW-1:0] st_last = '0;
  bit acc_prev = 0;

  logic [7:0] fr [0:127];
  logic [7:0] expb [0:127];

  always #2.5 clk = ~clk;

  rxq_word_packer #(.CNT_W(CW), .BYTES(BY)) i_rxq_word_packer (
    .clk(clk), .rst_n(rst_n), .cfg_strip_pad(cfg_strip_pad), .cfg_strip_crc(cfg_strip_crc),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_eof(in_eof),
    .in_ovf(in_ovf), .in_rxer(in_rxer), .in_odd(in_odd),
    .q_valid(q_valid), .q_ready(q_ready), .q_data(q_data), .q_be(q_be), .q_last(q_last),
    .st_full(st_full), .st_we(st_we), .st_word(st_word)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // queue back-pressure pattern, driven after each rising edge
  always @(posedge clk) begin
    #1;
    cyc++;
    q_ready = bp ? ((cyc % 3) != 0) : 1'b1;
  end

  // monitor, sampled at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (q_valid && q_ready) begin
        for (int j = 0; j < BY; j++)
          if (q_be[j] && got_n < 256) begin
            got[got_n] = q_data[8*j +: 8];
            got_n++;
          end
        if (q_last) last_n++;
        if (!q_last && q_be != '1) bad_be++;
      end
      if (st_we) begin
        st_last = st_word;
        st_n++;
      end
      if (in_valid && in_ready && acc_prev) pace_bad++;
      acc_prev = in_valid && in_ready;
    end
  end

  function automatic logic [31:0] crc_upd(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int k = 0; k < 8; k++) r = (r[0] ^ b[k]) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  task automatic build(input int n, input bit bad);
    logic [31:0] c;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < n - 4; i++) begin
      if (i == 12)      fr[i] = 8'h00;
      else if (i == 13) fr[i] = 8'((n * 7) % 64);
      else              fr[i] = 8'(i * 13 + n);
      c = crc_upd(c, fr[i]);
    end
    c = ~c;
    for (int k = 0; k < 4; k++) fr[n-4+k] = c[8*k +: 8];
    if (bad) fr[0] = fr[0] ^ 8'h5A;
  endtask

  task automatic send(input int n, input int a_ovf, input int a_rxer, input int a_odd);
    for (int i = 0; i < n; i++) begin
      bit took;
      in_valid = 1'b1;
      in_data  = fr[i];
      in_eof   = (i == n - 1);
      in_ovf   = (i == a_ovf);
      in_rxer  = (i == a_rxer);
      in_odd   = (i == a_odd);
      do begin
        @(negedge clk);
        took = in_ready;
        @(posedge clk);
        #1;
      end while (!took);
    end
    in_valid = 1'b0;
    in_eof = 1'b0; in_ovf = 1'b0; in_rxer = 1'b0; in_odd = 1'b0;
  endtask

  task automatic run_frame(input int n, input bit bad, input bit sp, input bit sc, input bit bpm,
                           input int a_ovf, input int a_rxer, input int a_odd, input bit full);
    int exp_n, l0, s0, lenv, mis;
    string tag;
    cfg_strip_pad = sp;
    cfg_strip_crc = sc;
    bp = bpm;
    st_full = full;
    got_n = 0;
    l0 = last_n;
    s0 = st_n;
    build(n, bad);
    lenv = (n >= 14) ? {fr[12], fr[13]} : 0;
    exp_n = 0;
    for (int i = 0; i < n; i++) begin
      bit keep;
      if (i >= n - 4) keep = !sc;
      else            keep = !(sp && lenv < 46 && i >= 14 + lenv);
      if (keep) begin
        expb[exp_n] = fr[i];
        exp_n++;
      end
    end
    send(n, a_ovf, a_rxer, a_odd);
    repeat (30) @(posedge clk);
    #1;
    st_full = 1'b0;
    if (full) begin
      chk(got_n == 0, "R9 words from dropped frame", got_n, 0);
      chk(st_n == s0, "R9 status from dropped frame", st_n - s0, 0);
    end else begin
      tag = sc ? "R7 stored byte count" : (sp ? "R8 stored byte count" : "R1 stored byte count");
      chk(got_n == exp_n, tag, got_n, exp_n);
      mis = 0;
      for (int i = 0; i < exp_n && i < got_n; i++) if (got[i] !== expb[i]) mis++;
      chk(mis == 0, bpm ? "R10 byte order under back-pressure" : "R1 byte order", mis, 0);
      chk(last_n - l0 == ((exp_n > 0) ? 1 : 0), "R2 last-word count", last_n - l0, (exp_n > 0) ? 1 : 0);
      chk(st_n - s0 == 1, "R4 status writes per frame", st_n - s0, 1);
      chk(int'(st_last[4 +: CW]) == n, "R4 frame length field", int'(st_last[4 +: CW]), n);
      chk(int'(st_last[4+CW +: CW]) == exp_n, "R4 stored length field", int'(st_last[4+CW +: CW]), exp_n);
      chk(st_last[0] == bad, "R6 crc error bit", int'(st_last[0]), int'(bad));
      chk(st_last[3:1] == {a_odd >= 0, a_rxer >= 0, a_ovf >= 0}, "R5 accumulated flags",
          int'(st_last[3:1]), int'({a_odd >= 0, a_rxer >= 0, a_ovf >= 0}));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R11 in_ready after reset", int'(in_ready), 1);
    chk(q_valid == 1'b0, "R11 q_valid after reset", int'(q_valid), 0);
    chk(st_we == 1'b0, "R11 st_we after reset", int'(st_we), 0);
    @(posedge clk);
    #1;

    // sweep of lengths, strip settings and back-pressure
    for (int n = 4; n <= 72; n++)
      for (int m = 0; m < 4; m++)
        run_frame(n, 1'b0, m[0], m[1], n[0] ^ m[0], -1, -1, -1, 1'b0);

    // corrupted CRC (R6)
    run_frame(64, 1'b1, 1'b0, 1'b0, 1'b0, -1, -1, -1, 1'b0);
    run_frame(70, 1'b1, 1'b1, 1'b1, 1'b1, -1, -1, -1, 1'b0);

    // status flags accumulate and then clear (R5)
    run_frame(40, 1'b0, 1'b0, 1'b0, 1'b0, 5, -1, -1, 1'b0);
    run_frame(40, 1'b0, 1'b0, 1'b0, 1'b0, -1, 39, -1, 1'b0);
    run_frame(40, 1'b0, 1'b0, 1'b0, 1'b1, -1, -1, 39, 1'b0);
    run_frame(41, 1'b0, 1'b0, 1'b0, 1'b0, 2, 20, 40, 1'b0);
    run_frame(40, 1'b0, 1'b0, 1'b0, 1'b0, -1, -1, -1, 1'b0);

    // status FIFO full at frame start (R9), then a normal frame
    run_frame(50, 1'b0, 1'b0, 1'b0, 1'b0, -1, -1, -1, 1'b1);
    run_frame(9, 1'b0, 1'b0, 1'b0, 1'b1, -1, -1, -1, 1'b1);
    run_frame(50, 1'b0, 1'b0, 1'b0, 1'b0, -1, -1, -1, 1'b0);

    chk(pace_bad == 0, "R3 back-to-back reads", pace_bad, 0);
    chk(bad_be == 0, "R1 partial non-final words", bad_be, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule